// File: doc/BRIEF.md
# External Bus Access Phase Sequencer

This block times a single read or write on an external memory-style bus. A request carries a zone number, a direction, an address and write data. Once the block takes it, the access runs through three phases in sequence: a lead phase, an active phase and a trail phase. The duration of each phase is counted in cycles of the block clock, which is the bus timing clock. Clock division happens outside the block.

Each zone has its own timing word. The word holds separate lead, active and trail fields for reads and for writes, plus a doubling flag. When doubling is set, the lead, trail and base active counts are multiplied by two. The extra active cycle and any wait states requested by the external device through the ready input are never doubled. The block does not check the fields for legal values: a zero lead or trail removes that phase, and a zero active field gives one active cycle.

Chip select stays high for the whole access. The read or write strobe is high only during the active phase. Write data is driven from the start of lead to the end of trail. Read data is captured at the end of the active phase. A one-cycle done pulse marks the end of each access.

Top module: `ext_bus_seq`

## Requirements
- R1: Every access asserts `cs_o` for a continuous run of cycles made of lead cycles (strobe low), then active cycles (strobe high), then trail cycles (strobe low). No strobe is ever high while `cs_o` is low.
- R2: The timing word of zone z is the slice `zone_cfg_i[z*19 +: 19]`. Its bits are laid out as follows: [2:0] read lead, [5:3] read active, [8:6] read trail, [11:9] write lead, [14:12] write active, [17:15] write trail, [18] doubling. Reads use the read fields of the requested zone and writes use the write fields.
- R3: With doubling clear, lead lasts exactly the lead field value and trail lasts exactly the trail field value. A field value of 0 skips that phase, which then takes no cycles.
- R4: The active phase lasts base + 1 + W cycles, where base is the active field value and W is the number of wait states. `ready_i` is sampled once per cycle from the last non-wait active cycle onward. Each low sample adds one active cycle, and the phase ends at the first high sample.
- R5: With doubling set, lead and trail last twice their field values, and the active base is twice the active field value. The +1 cycle and the wait states W are not doubled.
- R6: A read asserts only `rd_o` and a write asserts only `wr_o`. The two strobes are never high together.
- R7: During every cycle of a write access, `wdata_oe_o` is 1 and `wdata_o` equals the request's write data. During a read access, `wdata_oe_o` stays 0. `addr_o` holds the request address for the whole access.
- R8: For a read, `rdata_o` takes the `rdata_i` value present in the last active cycle and holds it until the next read completes. A write leaves `rdata_o` unchanged.
- R9: `done_o` is high for exactly one cycle, in the first cycle after the last `cs_o` cycle, and `cs_o` is low in that cycle.
- R10: A request is taken only when no access is in progress. A request raised during an access is ignored, so no second access follows it.
- R11: The timing word and request fields are latched when the access starts. Changes to `zone_cfg_i` during the access do not alter its phase lengths.
- R12: While `rst_ni` is low, `cs_o`, `rd_o`, `wr_o`, `wdata_oe_o` and `done_o` are 0 and `rdata_o` is 0. An access in progress is abandoned at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_zone_i | input | ZONE_W | Zone number of the access |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| zone_cfg_i | input | NUM_ZONES*19 | Per-zone timing words |
| ready_i | input | 1 | External ready; low requests wait states |
| rdata_i | input | DATA_W | Read data from the bus |
| cs_o | output | 1 | Chip select, high for the whole access |
| rd_o | output | 1 | Read strobe, active phase of reads |
| wr_o | output | 1 | Write strobe, active phase of writes |
| addr_o | output | ADDR_W | Latched access address |
| wdata_o | output | DATA_W | Latched write data |
| wdata_oe_o | output | 1 | Write data drive enable |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
The main function is run with a set of timing words that cover reads and writes, each zone, doubling on and off, zero lead and trail fields, the all-zero word and the all-maximum word, and wait-state counts from zero to four. Measuring the lead, active and trail lengths separately shows whether each phase was counted correctly. It also shows whether a doubling error falls on the right terms, since the wait states and the extra cycle must stay undoubled. Every other zone and the unused direction hold different values, so picking the wrong zone or the wrong read/write field set changes the measured lengths. A request and a changed timing word are injected mid-access to tell latched behaviour from live behaviour. Read data changes every cycle, which shows exactly which active cycle was captured.

// File: rtl/ext_bus_seq_pkg.sv
package ext_bus_seq_pkg;

  localparam int unsigned FIELD_W = 3;
  localparam int unsigned LEN_W   = FIELD_W + 1;  // doubled lead/trail
  localparam int unsigned CNT_W   = FIELD_W + 2;  // doubled active + 1

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_ACT   = 2'd2,
    PH_TRAIL = 2'd3
  } phase_e;

  typedef struct packed {
    logic               dbl;
    logic [FIELD_W-1:0] wr_trail;
    logic [FIELD_W-1:0] wr_act;
    logic [FIELD_W-1:0] wr_lead;
    logic [FIELD_W-1:0] rd_trail;
    logic [FIELD_W-1:0] rd_act;
    logic [FIELD_W-1:0] rd_lead;
  } zone_cfg_t;

  localparam int unsigned CFG_W = $bits(zone_cfg_t);

  function automatic logic [LEN_W-1:0] scale_len(input logic [FIELD_W-1:0] f,
                                                 input logic dbl);
    return dbl ? {f, 1'b0} : {1'b0, f};
  endfunction

endpackage

// File: rtl/ebs_cfg_sel.sv
module ebs_cfg_sel
  import ext_bus_seq_pkg::*;
#(
  parameter int unsigned NUM_ZONES = 4,
  parameter int unsigned ZONE_W    = 2
) (
  input  logic [NUM_ZONES*CFG_W-1:0] zone_cfg_i,
  input  logic [ZONE_W-1:0]          zone_i,
  input  logic                       write_i,
  output logic [LEN_W-1:0]           lead_len_o,
  output logic [CNT_W-1:0]           act_len_o,
  output logic [LEN_W-1:0]           trail_len_o
);

  zone_cfg_t cfg_arr [NUM_ZONES];
  zone_cfg_t sel;

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    assign cfg_arr[z] = zone_cfg_t'(zone_cfg_i[z*CFG_W +: CFG_W]);
  end

  logic [FIELD_W-1:0] lead_f, act_f, trail_f;
  logic [LEN_W-1:0]   act_base;

  always_comb begin
    sel = cfg_arr[0];
    for (int z = 0; z < NUM_ZONES; z++) begin
      if (zone_i == ZONE_W'(z)) sel = cfg_arr[z];
    end
    lead_f  = write_i ? sel.wr_lead  : sel.rd_lead;
    act_f   = write_i ? sel.wr_act   : sel.rd_act;
    trail_f = write_i ? sel.wr_trail : sel.rd_trail;
  end

  assign lead_len_o  = scale_len(lead_f, sel.dbl);
  assign trail_len_o = scale_len(trail_f, sel.dbl);
  assign act_base    = scale_len(act_f, sel.dbl);
  // the extra active cycle is added after scaling: never doubled
  assign act_len_o   = CNT_W'(act_base) + CNT_W'(1);

endmodule

// File: rtl/ebs_phase_ctl.sv
module ebs_phase_ctl
  import ext_bus_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] lead_len_i,
  input  logic [CNT_W-1:0] act_len_i,
  input  logic [LEN_W-1:0] trail_len_i,
  input  logic             ready_i,
  output phase_e           phase_o,
  output logic             idle_o,
  output logic             act_last_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;
  logic [LEN_W-1:0] trail_q;
  logic             done_q;
  logic             cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign idle_o     = (phase_q == PH_IDLE);
  assign act_last_o = (phase_q == PH_ACT) && cnt_zero && ready_i;
  assign phase_o    = phase_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      trail_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            act_q   <= act_len_i;
            trail_q <= trail_len_i;
            if (lead_len_i != '0) begin
              phase_q <= PH_LEAD;
              cnt_q   <= CNT_W'(lead_len_i) - ONE;
            end else begin
              phase_q <= PH_ACT;
              cnt_q   <= act_len_i - ONE;
            end
          end
        end
        PH_LEAD: begin
          if (cnt_zero) begin
            phase_q <= PH_ACT;
            cnt_q   <= act_q - ONE;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        PH_ACT: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - ONE;
          end else if (ready_i) begin
            if (trail_q != '0) begin
              phase_q <= PH_TRAIL;
              cnt_q   <= CNT_W'(trail_q) - ONE;
            end else begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          end
          // count exhausted and ready low: wait state, hold
        end
        PH_TRAIL: begin
          if (cnt_zero) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ebs_bus_drv.sv
module ebs_bus_drv
  import ext_bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  phase_e            phase_i,
  input  logic              act_last_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wdata_oe_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start_i) begin
        write_q <= write_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (act_last_i && !write_q) rdata_q <= rdata_i;
    end
  end

  logic busy;
  logic active;

  assign busy       = (phase_i != PH_IDLE);
  assign active     = (phase_i == PH_ACT);
  assign cs_o       = busy;
  assign rd_o       = active && !write_q;
  assign wr_o       = active && write_q;
  assign wdata_oe_o = busy && write_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_seq_pkg::*;
#(
  parameter int unsigned NUM_ZONES = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned ZONE_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       req_write_i,
  input  logic [ZONE_W-1:0]          req_zone_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [DATA_W-1:0]          req_wdata_i,
  input  logic [NUM_ZONES*CFG_W-1:0] zone_cfg_i,
  input  logic                       ready_i,
  input  logic [DATA_W-1:0]          rdata_i,
  output logic                       cs_o,
  output logic                       rd_o,
  output logic                       wr_o,
  output logic [ADDR_W-1:0]          addr_o,
  output logic [DATA_W-1:0]          wdata_o,
  output logic                       wdata_oe_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       done_o
);

  logic [LEN_W-1:0] lead_len, trail_len;
  logic [CNT_W-1:0] act_len;
  phase_e           phase;
  logic             idle, act_last, start;

  assign start = req_i && idle;

  ebs_cfg_sel #(
    .NUM_ZONES(NUM_ZONES),
    .ZONE_W   (ZONE_W)
  ) u_cfg_sel (
    .zone_cfg_i (zone_cfg_i),
    .zone_i     (req_zone_i),
    .write_i    (req_write_i),
    .lead_len_o (lead_len),
    .act_len_o  (act_len),
    .trail_len_o(trail_len)
  );

  ebs_phase_ctl u_phase_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .lead_len_i (lead_len),
    .act_len_i  (act_len),
    .trail_len_i(trail_len),
    .ready_i    (ready_i),
    .phase_o    (phase),
    .idle_o     (idle),
    .act_last_o (act_last),
    .done_o     (done_o)
  );

  ebs_bus_drv #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_bus_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .write_i   (req_write_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .phase_i   (phase),
    .act_last_i(act_last),
    .rdata_i   (rdata_i),
    .cs_o      (cs_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .addr_o    (addr_o),
    .wdata_o   (wdata_o),
    .wdata_oe_o(wdata_oe_o),
    .rdata_o   (rdata_o)
  );

endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              cs_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic              wdata_oe_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o
);

  p_strobe_in_cs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> cs_o);

  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cs_o) && !cs_o));

  p_wait_on_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_o || wr_o) |-> $past(ready_i));

  p_oe_in_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_oe_o |-> cs_o);

  p_addr_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $past(cs_o)) |-> $stable(addr_o));

endmodule

bind ext_bus_seq ext_bus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (ready_i),
  .cs_o      (cs_o),
  .rd_o      (rd_o),
  .wr_o      (wr_o),
  .wdata_oe_o(wdata_oe_o),
  .done_o    (done_o),
  .addr_o    (addr_o)
);

// File: tb/ext_bus_seq_bench.sv
`timescale 1ns/1ps
module ext_bus_seq_bench;

  localparam int NZ = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 19;

  typedef struct packed {
    logic [7:0] zone;
    logic [7:0] wr;
    logic [7:0] lead;
    logic [7:0] act;
    logic [7:0] trail;
    logic [7:0] dbl;
    logic [7:0] ws;
    logic [7:0] el;
    logic [7:0] ea;
    logic [7:0] et;
  } vec_t;

  localparam int NV = 8;
  // zone wr lead act trail dbl ws | exp lead act trail
  localparam vec_t VECS [NV] = '{
    '{8'd0, 8'd0, 8'd1, 8'd2, 8'd1, 8'd0, 8'd0, 8'd1,  8'd3,  8'd1},
    '{8'd1, 8'd1, 8'd2, 8'd3, 8'd2, 8'd0, 8'd2, 8'd2,  8'd6,  8'd2},
    '{8'd2, 8'd0, 8'd3, 8'd1, 8'd2, 8'd1, 8'd0, 8'd6,  8'd3,  8'd4},
    '{8'd3, 8'd1, 8'd1, 8'd4, 8'd3, 8'd1, 8'd3, 8'd2,  8'd12, 8'd6},
    '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,  8'd1,  8'd0},
    '{8'd1, 8'd1, 8'd0, 8'd2, 8'd0, 8'd1, 8'd1, 8'd0,  8'd6,  8'd0},
    '{8'd2, 8'd0, 8'd7, 8'd7, 8'd7, 8'd1, 8'd0, 8'd14, 8'd15, 8'd14},
    '{8'd3, 8'd1, 8'd0, 8'd5, 8'd4, 8'd0, 8'd4, 8'd0,  8'd10, 8'd4}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic             req_write_i = 1'b0;
  logic [1:0]       req_zone_i = '0;
  logic [AW-1:0]    req_addr_i = '0;
  logic [DW-1:0]    req_wdata_i = '0;
  logic [NZ*CW-1:0] zone_cfg_i = '0;
  logic             ready_i = 1'b1;
  logic [DW-1:0]    rdata_i = '0;
  logic             cs_o, rd_o, wr_o, wdata_oe_o, done_o;
  logic [AW-1:0]    addr_o;
  logic [DW-1:0]    wdata_o, rdata_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  ext_bus_seq u_ext_bus_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_write_i(req_write_i),
    .req_zone_i (req_zone_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .zone_cfg_i (zone_cfg_i),
    .ready_i    (ready_i),
    .rdata_i    (rdata_i),
    .cs_o       (cs_o),
    .rd_o       (rd_o),
    .wr_o       (wr_o),
    .addr_o     (addr_o),
    .wdata_o    (wdata_o),
    .wdata_oe_o (wdata_oe_o),
    .rdata_o    (rdata_o),
    .done_o     (done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R2 layout: [18] dbl, [17:15] wr trail, [14:12] wr act, [11:9] wr lead,
  // [8:6] rd trail, [5:3] rd act, [2:0] rd lead; unused direction set to 6
  function automatic logic [CW-1:0] pack(input bit wr, input logic [2:0] l,
      input logic [2:0] a, input logic [2:0] t, input bit dbl);
    if (wr) return {dbl, t, a, l, 3'd6, 3'd6, 3'd6};
    else    return {dbl, 3'd6, 3'd6, 3'd6, t, a, l};
  endfunction

  localparam logic [CW-1:0] FILLER = {1'b1, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5};

  task automatic run_vec(input int idx, input vec_t v);
    int nl, na, nt, cyc, bad_oe, bad_stb;
    bit seen, done_seen, cs_at_done, stb, other, wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rd_prev, exp_rd;
    wr = v.wr[0];
    addr = AW'(16'h1000 + idx);
    wdata = DW'(16'hA500 + idx);
    rd_prev = rdata_o;
    @(negedge clk_i);
    for (int z = 0; z < NZ; z++) zone_cfg_i[z*CW +: CW] = FILLER;
    zone_cfg_i[v.zone[1:0]*CW +: CW] = pack(wr, v.lead[2:0], v.act[2:0], v.trail[2:0], v.dbl[0]);
    req_i = 1'b1; req_write_i = wr; req_zone_i = v.zone[1:0];
    req_addr_i = addr; req_wdata_i = wdata;
    @(negedge clk_i);
    req_i = 1'b0;
    nl = 0; na = 0; nt = 0; cyc = 0; bad_oe = 0; bad_stb = 0;
    seen = 0; done_seen = 0; cs_at_done = 0;
    while (!done_seen && cyc < 200) begin
      req_i = 1'b0;
      ready_i = 1'b1;
      if (done_o) begin
        done_seen = 1; cs_at_done = cs_o;
      end else begin
        stb = wr ? wr_o : rd_o;
        other = wr ? rd_o : wr_o;
        if (other) bad_stb++;
        if (cs_o) begin
          if (stb) begin
            na++; seen = 1;
            ready_i = (na >= v.ea);
            rdata_i = {8'(idx), 8'(na)};
          end else if (!seen) nl++;
          else nt++;
          if (wdata_oe_o !== wr) bad_oe++;
          if (wr && wdata_o !== wdata) bad_oe++;
          if (addr_o !== addr) bad_oe++;
          if (cyc == 1) begin
            // R10/R11: request and timing change while busy
            req_i = 1'b1; req_zone_i = ~v.zone[1:0]; req_write_i = ~wr;
            zone_cfg_i = '1;
          end
        end else if (stb) bad_stb++;
        cyc++;
        @(negedge clk_i);
      end
    end
    req_i = 1'b0;
    ready_i = 1'b1;
    check(nl == v.el, "R3/R5/R2", $sformatf("vec %0d lead cycles", idx), nl, v.el);
    check(na == v.ea, "R4/R5", $sformatf("vec %0d active cycles", idx), na, v.ea);
    check(nt == v.et, "R3/R5/R11", $sformatf("vec %0d trail cycles", idx), nt, v.et);
    check(bad_stb == 0, "R6/R1", $sformatf("vec %0d wrong strobe cycles", idx), bad_stb, 0);
    check(bad_oe == 0, "R7", $sformatf("vec %0d data/addr drive errors", idx), bad_oe, 0);
    check(done_seen && !cs_at_done, "R9", $sformatf("vec %0d done after cs", idx),
          done_seen, 1);
    exp_rd = wr ? rd_prev : {8'(idx), v.ea};
    check(rdata_o === exp_rd, "R8", $sformatf("vec %0d read data", idx), rdata_o, exp_rd);
    @(negedge clk_i);
    check(done_o === 1'b0, "R9", $sformatf("vec %0d done width", idx), done_o, 0);
    begin
      int extra = 0;
      for (int k = 0; k < 3; k++) begin
        if (cs_o) extra++;
        @(negedge clk_i);
      end
      check(extra == 0, "R10", $sformatf("vec %0d access after busy request", idx), extra, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk_i);
    check({cs_o, rd_o, wr_o, wdata_oe_o, done_o} == 5'b0, "R12", "strobes in reset",
          {cs_o, rd_o, wr_o, wdata_oe_o, done_o}, 0);
    check(rdata_o === '0, "R12", "rdata in reset", rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cs_o === 1'b0, "R12", "idle after reset", cs_o, 0);

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // R12: abandon an access mid-way
    @(negedge clk_i);
    for (int z = 0; z < NZ; z++) zone_cfg_i[z*CW +: CW] = pack(1'b1, 3'd7, 3'd7, 3'd7, 1'b1);
    req_i = 1'b1; req_write_i = 1'b1; req_zone_i = 2'd1;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(cs_o === 1'b1 && wdata_oe_o === 1'b1, "R1", "cs during long lead", cs_o, 1);
    rst_ni = 1'b0;
    #1;
    check({cs_o, wr_o, wdata_oe_o, done_o} == 4'b0, "R12", "async abandon",
          {cs_o, wr_o, wdata_oe_o, done_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    begin
      int busy = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk_i);
        if (cs_o || done_o) busy++;
      end
      check(busy == 0, "R12", "no resume after reset", busy, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule